// File: doc/BRIEF.md
# Tagged IO Translation Cache

This block is a small fully associative store of IO address translations for an IO memory management unit. Each entry pairs a lookup key with a result. The key is a translation-mode tag, a guest context ID, a process context ID and a virtual page number. The result is a physical page number and permission bits. Entries with different tags are kept apart, so a flush aimed at one translation mode never disturbs translations cached under another.

A lookup presents the current context's two translation-pointer mode fields, its IDs and a page number. The block derives the tag from the two mode fields and returns a registered hit, physical page and permissions one cycle later. After a page walk, a fill writes a new translation; the fill's tag is derived the same way. An invalidation presents a tag, three enable bits, IDs and a page number. In one cycle it sets the permissions of every matching entry to none, and from then on those entries miss.

Top module: `iotc_top`

## Requirements
- R1: After reset every entry holds permission none, so every lookup misses, and the response-valid output is low until a lookup has been requested.
- R2: The tag is a 2-bit code built from two mode fields, where a mode field equal to zero means bare. Bit 0 is set when the first-stage mode is not bare, and bit 1 is set when the second-stage mode is not bare. This gives bypass 0, single-stage 1, G-stage-only 2 and nested 3. Two mode encodings that both mean "not bare" give the same tag.
- R3: A lookup requested in cycle t answers in cycle t+1 with response-valid high. It hits only if a stored entry equals the request in tag, guest ID, process ID and page number, and that entry's permission is not zero (zero means none). On a hit the outputs carry the stored physical page and permissions. On a miss both are zero.
- R4: A fill stores the tag derived from its own mode fields, together with its guest ID, process ID, page number, physical page and permissions.
- R5: A fill whose key equals a live entry (permission not zero) overwrites that entry in place, and the replacement pointer does not move. Any other fill goes to the slot the round-robin pointer names. The pointer starts at slot 0 after reset and advances by one per such fill, wrapping at ENTRIES.
- R6: An invalidation clears the permission of every entry whose tag equals the invalidation tag and which also matches on each field whose enable is set (guest ID, process ID, page number). With no enables set, it clears every entry carrying that tag.
- R7: An invalidation or fill in cycle t has no effect on a lookup requested in cycle t. It is visible to a lookup requested in cycle t+1.
- R8: When a fill and an invalidation happen in the same cycle, the entry written by the fill holds the fill's permissions afterwards, even if its fields match the invalidation.
- R9: An invalidation leaves untouched every entry whose tag differs from the invalidation tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_fs_mode | input | MODE_W (4) | First-stage mode field of the lookup context, 0 = bare |
| lk_gs_mode | input | MODE_W (4) | Second-stage mode field of the lookup context, 0 = bare |
| lk_gscid | input | GSC_W (16) | Lookup guest context ID |
| lk_pscid | input | PSC_W (20) | Lookup process context ID |
| lk_vpn | input | VPN_W (44) | Lookup virtual page number |
| lk_rsp_valid | output | 1 | Lookup response valid, one cycle after lk_req |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | PPN_W (44) | Physical page on hit, else zero |
| lk_perm | output | PERM_W (2) | Permissions on hit, else zero |
| fl_en | input | 1 | Fill strobe |
| fl_fs_mode | input | MODE_W (4) | First-stage mode field for the fill |
| fl_gs_mode | input | MODE_W (4) | Second-stage mode field for the fill |
| fl_gscid | input | GSC_W (16) | Fill guest context ID |
| fl_pscid | input | PSC_W (20) | Fill process context ID |
| fl_vpn | input | VPN_W (44) | Fill virtual page number |
| fl_ppn | input | PPN_W (44) | Fill physical page number |
| fl_perm | input | PERM_W (2) | Fill permissions |
| iv_en | input | 1 | Invalidation strobe |
| iv_use_gscid | input | 1 | Invalidation also matches guest ID |
| iv_use_pscid | input | 1 | Invalidation also matches process ID |
| iv_use_vpn | input | 1 | Invalidation also matches page number |
| iv_tag | input | 2 | Invalidation tag (encoding of R2) |
| iv_gscid | input | GSC_W (16) | Invalidation guest context ID |
| iv_pscid | input | PSC_W (20) | Invalidation process context ID |
| iv_vpn | input | VPN_W (44) | Invalidation page number |

## Verification
A wrong stored tag, ID or permission shows up at the lookup outputs one cycle after the next lookup that touches the entry: a hit turns into a miss, a miss into a hit, or the physical page is wrong. A fault in the replacement pointer stays hidden until the pool wraps. It then appears as the wrong survivor when the seventeenth distinct key is filled, or as an in-place refill that evicts a neighbour. A wrong invalidation mask shows at the next lookup of each entry. For that reason every entry is looked up after each of the eight enable combinations, with entries of a second tag present.

// File: rtl/iotc_pkg.sv
package iotc_pkg;

    typedef enum logic [1:0] {
        XT_BYPASS = 2'd0,
        XT_SINGLE = 2'd1,
        XT_GONLY  = 2'd2,
        XT_NESTED = 2'd3
    } xlat_tag_e;

    localparam int MODE_BARE = 0;

    function automatic xlat_tag_e derive_tag(input logic fs_on, input logic gs_on);
        xlat_tag_e t;
        case ({gs_on, fs_on})
            2'b00:   t = XT_BYPASS;
            2'b01:   t = XT_SINGLE;
            2'b10:   t = XT_GONLY;
            default: t = XT_NESTED;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/iotc_tag_derive.sv
module iotc_tag_derive #(
    parameter int MODE_W = 4
) (
    input  logic [MODE_W-1:0]    fs_mode,
    input  logic [MODE_W-1:0]    gs_mode,
    output iotc_pkg::xlat_tag_e  tag
);
    assign tag = iotc_pkg::derive_tag(fs_mode != MODE_W'(iotc_pkg::MODE_BARE),
                                      gs_mode != MODE_W'(iotc_pkg::MODE_BARE));
endmodule

// File: rtl/iotc_key_cam.sv
module iotc_key_cam #(
    parameter int N     = 16,
    parameter int GSC_W = 16,
    parameter int PSC_W = 20,
    parameter int VPN_W = 44
) (
    input  logic [N-1:0]            live,
    input  logic [N-1:0][1:0]       e_tag,
    input  logic [N-1:0][GSC_W-1:0] e_gsc,
    input  logic [N-1:0][PSC_W-1:0] e_psc,
    input  logic [N-1:0][VPN_W-1:0] e_vpn,
    input  logic [1:0]              q_tag,
    input  logic [GSC_W-1:0]        q_gsc,
    input  logic [PSC_W-1:0]        q_psc,
    input  logic [VPN_W-1:0]        q_vpn,
    output logic [N-1:0]            match
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign match[i] = live[i] && (e_tag[i] == q_tag) && (e_gsc[i] == q_gsc) &&
                          (e_psc[i] == q_psc) && (e_vpn[i] == q_vpn);
    end
endmodule

// File: rtl/iotc_inval_sel.sv
module iotc_inval_sel #(
    parameter int N     = 16,
    parameter int GSC_W = 16,
    parameter int PSC_W = 20,
    parameter int VPN_W = 44
) (
    input  logic                    en,
    input  logic                    use_gsc,
    input  logic                    use_psc,
    input  logic                    use_vpn,
    input  logic [N-1:0][1:0]       e_tag,
    input  logic [N-1:0][GSC_W-1:0] e_gsc,
    input  logic [N-1:0][PSC_W-1:0] e_psc,
    input  logic [N-1:0][VPN_W-1:0] e_vpn,
    input  logic [1:0]              q_tag,
    input  logic [GSC_W-1:0]        q_gsc,
    input  logic [PSC_W-1:0]        q_psc,
    input  logic [VPN_W-1:0]        q_vpn,
    output logic [N-1:0]            clr
);
    for (genvar i = 0; i < N; i++) begin : g_sel
        assign clr[i] = en && (e_tag[i] == q_tag) &&
                        (!use_gsc || (e_gsc[i] == q_gsc)) &&
                        (!use_psc || (e_psc[i] == q_psc)) &&
                        (!use_vpn || (e_vpn[i] == q_vpn));
    end
endmodule

// File: rtl/iotc_rr_ptr.sv
module iotc_rr_ptr #(
    parameter int N = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [IW-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (adv) begin
            ptr <= (ptr == IW'(N - 1)) ? '0 : ptr + IW'(1);
        end
    end
endmodule

// File: rtl/iotc_top.sv
module iotc_top
    import iotc_pkg::*;
#(
    parameter int N      = 16,
    parameter int MODE_W = 4,
    parameter int GSC_W  = 16,
    parameter int PSC_W  = 20,
    parameter int VPN_W  = 44,
    parameter int PPN_W  = 44,
    parameter int PERM_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_req,
    input  logic [MODE_W-1:0] lk_fs_mode,
    input  logic [MODE_W-1:0] lk_gs_mode,
    input  logic [GSC_W-1:0]  lk_gscid,
    input  logic [PSC_W-1:0]  lk_pscid,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              lk_rsp_valid,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic [PERM_W-1:0] lk_perm,
    input  logic              fl_en,
    input  logic [MODE_W-1:0] fl_fs_mode,
    input  logic [MODE_W-1:0] fl_gs_mode,
    input  logic [GSC_W-1:0]  fl_gscid,
    input  logic [PSC_W-1:0]  fl_pscid,
    input  logic [VPN_W-1:0]  fl_vpn,
    input  logic [PPN_W-1:0]  fl_ppn,
    input  logic [PERM_W-1:0] fl_perm,
    input  logic              iv_en,
    input  logic              iv_use_gscid,
    input  logic              iv_use_pscid,
    input  logic              iv_use_vpn,
    input  logic [1:0]        iv_tag,
    input  logic [GSC_W-1:0]  iv_gscid,
    input  logic [PSC_W-1:0]  iv_pscid,
    input  logic [VPN_W-1:0]  iv_vpn
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0][1:0]        e_tag;
    logic [N-1:0][GSC_W-1:0]  e_gsc;
    logic [N-1:0][PSC_W-1:0]  e_psc;
    logic [N-1:0][VPN_W-1:0]  e_vpn;
    logic [N-1:0][PPN_W-1:0]  e_ppn;
    logic [N-1:0][PERM_W-1:0] e_perm;
    logic [N-1:0]             live;

    xlat_tag_e                lk_tag;
    xlat_tag_e                fl_tag;
    logic [N-1:0]             lk_match;
    logic [N-1:0]             fl_match;
    logic [N-1:0]             iv_clr;
    logic                     fl_any;
    logic [IW-1:0]            rr_slot;
    logic [IW-1:0]            fl_slot;
    logic [PPN_W-1:0]         sel_ppn;
    logic [PERM_W-1:0]        sel_perm;

    for (genvar i = 0; i < N; i++) begin : g_live
        assign live[i] = |e_perm[i];
    end

    iotc_tag_derive #(.MODE_W(MODE_W)) u_lk_tag (
        .fs_mode(lk_fs_mode), .gs_mode(lk_gs_mode), .tag(lk_tag));

    iotc_tag_derive #(.MODE_W(MODE_W)) u_fl_tag (
        .fs_mode(fl_fs_mode), .gs_mode(fl_gs_mode), .tag(fl_tag));

    iotc_key_cam #(.N(N), .GSC_W(GSC_W), .PSC_W(PSC_W), .VPN_W(VPN_W)) u_lk_cam (
        .live(live), .e_tag(e_tag), .e_gsc(e_gsc), .e_psc(e_psc), .e_vpn(e_vpn),
        .q_tag(lk_tag), .q_gsc(lk_gscid), .q_psc(lk_pscid), .q_vpn(lk_vpn),
        .match(lk_match));

    iotc_key_cam #(.N(N), .GSC_W(GSC_W), .PSC_W(PSC_W), .VPN_W(VPN_W)) u_fl_cam (
        .live(live), .e_tag(e_tag), .e_gsc(e_gsc), .e_psc(e_psc), .e_vpn(e_vpn),
        .q_tag(fl_tag), .q_gsc(fl_gscid), .q_psc(fl_pscid), .q_vpn(fl_vpn),
        .match(fl_match));

    iotc_inval_sel #(.N(N), .GSC_W(GSC_W), .PSC_W(PSC_W), .VPN_W(VPN_W)) u_iv_sel (
        .en(iv_en), .use_gsc(iv_use_gscid), .use_psc(iv_use_pscid), .use_vpn(iv_use_vpn),
        .e_tag(e_tag), .e_gsc(e_gsc), .e_psc(e_psc), .e_vpn(e_vpn),
        .q_tag(iv_tag), .q_gsc(iv_gscid), .q_psc(iv_pscid), .q_vpn(iv_vpn),
        .clr(iv_clr));

    iotc_rr_ptr #(.N(N)) u_rr (
        .clk(clk), .rst(rst), .adv(fl_en && !fl_any), .ptr(rr_slot));

    // Fill target: the live entry with the same key, else the round-robin slot.
    always_comb begin
        fl_any  = |fl_match;
        fl_slot = rr_slot;
        for (int i = 0; i < N; i++) begin
            if (fl_match[i]) fl_slot = IW'(i);
        end
    end

    // At most one live entry per key, so an OR of the matching rows selects it.
    always_comb begin
        sel_ppn  = '0;
        sel_perm = '0;
        for (int i = 0; i < N; i++) begin
            if (lk_match[i]) begin
                sel_ppn  = sel_ppn | e_ppn[i];
                sel_perm = sel_perm | e_perm[i];
            end
        end
    end

    // Invalidation clears first; a fill to the same slot in that cycle wins.
    always_ff @(posedge clk) begin
        if (rst) begin
            e_tag  <= '0;
            e_gsc  <= '0;
            e_psc  <= '0;
            e_vpn  <= '0;
            e_ppn  <= '0;
            e_perm <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (iv_clr[i]) e_perm[i] <= '0;
                if (fl_en && (fl_slot == IW'(i))) begin
                    e_tag[i]  <= fl_tag;
                    e_gsc[i]  <= fl_gscid;
                    e_psc[i]  <= fl_pscid;
                    e_vpn[i]  <= fl_vpn;
                    e_ppn[i]  <= fl_ppn;
                    e_perm[i] <= fl_perm;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_rsp_valid <= 1'b0;
            lk_hit       <= 1'b0;
            lk_ppn       <= '0;
            lk_perm      <= '0;
        end else begin
            lk_rsp_valid <= lk_req;
            lk_hit       <= lk_req && (|lk_match);
            lk_ppn       <= lk_req ? sel_ppn : '0;
            lk_perm      <= lk_req ? sel_perm : '0;
        end
    end

endmodule

// File: rtl/iotc_chk.sv
module iotc_chk #(
    parameter int N      = 16,
    parameter int PPN_W  = 44,
    parameter int PERM_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              lk_req,
    input logic              lk_rsp_valid,
    input logic              lk_hit,
    input logic [PPN_W-1:0]  lk_ppn,
    input logic [PERM_W-1:0] lk_perm,
    input logic [N-1:0]      lk_match,
    input logic [1:0]        lk_tag,
    input logic              iv_en,
    input logic              iv_use_gscid,
    input logic              iv_use_pscid,
    input logic              iv_use_vpn,
    input logic [1:0]        iv_tag,
    input logic              fl_en
);
    p_rsp_after_req_r3: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> lk_rsp_valid);

    p_no_rsp_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !lk_req |=> !lk_rsp_valid);

    p_hit_has_perm_r3: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (lk_rsp_valid && (lk_perm != '0)));

    p_miss_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (lk_rsp_valid && !lk_hit) |-> ((lk_ppn == '0) && (lk_perm == '0)));

    p_single_match_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_match));

    p_flush_tag_r6: assert property (@(posedge clk) disable iff (rst)
        (lk_req && $past(iv_en && !iv_use_gscid && !iv_use_pscid && !iv_use_vpn && !fl_en)
         && (lk_tag == $past(iv_tag))) |=> !lk_hit);
endmodule

bind iotc_top iotc_chk #(.N(N), .PPN_W(PPN_W), .PERM_W(PERM_W)) u_chk (
    .clk(clk), .rst(rst), .lk_req(lk_req), .lk_rsp_valid(lk_rsp_valid),
    .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_perm(lk_perm), .lk_match(lk_match),
    .lk_tag(lk_tag), .iv_en(iv_en), .iv_use_gscid(iv_use_gscid),
    .iv_use_pscid(iv_use_pscid), .iv_use_vpn(iv_use_vpn), .iv_tag(iv_tag),
    .fl_en(fl_en));

// File: tb/tb_iotc_top.sv
module tb_iotc_top;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic        lk_req;
    logic [3:0]  lk_fs_mode, lk_gs_mode;
    logic [15:0] lk_gscid;
    logic [19:0] lk_pscid;
    logic [43:0] lk_vpn;
    logic        lk_rsp_valid, lk_hit;
    logic [43:0] lk_ppn;
    logic [1:0]  lk_perm;
    logic        fl_en;
    logic [3:0]  fl_fs_mode, fl_gs_mode;
    logic [15:0] fl_gscid;
    logic [19:0] fl_pscid;
    logic [43:0] fl_vpn, fl_ppn;
    logic [1:0]  fl_perm;
    logic        iv_en, iv_use_gscid, iv_use_pscid, iv_use_vpn;
    logic [1:0]  iv_tag;
    logic [15:0] iv_gscid;
    logic [19:0] iv_pscid;
    logic [43:0] iv_vpn;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    iotc_top dut (.*);

    // Bench model of the stored state, kept from the requirements.
    logic [1:0]  m_tag [N];
    logic [15:0] m_g   [N];
    logic [19:0] m_p   [N];
    logic [43:0] m_v   [N];
    logic [43:0] m_ppn [N];
    logic [1:0]  m_perm[N];
    int          m_ptr;

    function automatic logic [1:0] tag_of(input logic [3:0] fs, input logic [3:0] gs);
        return {gs != 4'd0, fs != 4'd0};
    endfunction
    function automatic logic [3:0] fs_for(input logic [1:0] t);
        return t[0] ? 4'd9 : 4'd0;
    endfunction
    function automatic logic [3:0] gs_for(input logic [1:0] t);
        return t[1] ? 4'd5 : 4'd0;
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic model_fill(input logic [1:0] t, input logic [15:0] g, input logic [19:0] p,
                              input logic [43:0] v, input logic [43:0] pp, input logic [1:0] pm);
        int s = -1;
        for (int i = 0; i < N; i++)
            if (m_perm[i] != 0 && m_tag[i] == t && m_g[i] == g && m_p[i] == p && m_v[i] == v) s = i;
        if (s < 0) begin
            s = m_ptr;
            m_ptr = (m_ptr + 1) % N;
        end
        m_tag[s] = t; m_g[s] = g; m_p[s] = p; m_v[s] = v; m_ppn[s] = pp; m_perm[s] = pm;
    endtask

    task automatic model_inval(input logic [2:0] use3, input logic [1:0] t, input logic [15:0] g,
                               input logic [19:0] p, input logic [43:0] v);
        for (int i = 0; i < N; i++)
            if (m_tag[i] == t && (!use3[0] || m_g[i] == g) && (!use3[1] || m_p[i] == p) &&
                (!use3[2] || m_v[i] == v)) m_perm[i] = 2'd0;
    endtask

    function automatic logic [63:0] model_look(input logic [1:0] t, input logic [15:0] g,
                                               input logic [19:0] p, input logic [43:0] v);
        logic [63:0] r = '0;
        for (int i = 0; i < N; i++)
            if (m_perm[i] != 0 && m_tag[i] == t && m_g[i] == g && m_p[i] == p && m_v[i] == v)
                r = {17'd0, 1'b1, m_perm[i], m_ppn[i]};
        return r;
    endfunction

    task automatic idle();
        lk_req = 0; lk_fs_mode = 0; lk_gs_mode = 0; lk_gscid = 0; lk_pscid = 0; lk_vpn = 0;
        fl_en = 0; fl_fs_mode = 0; fl_gs_mode = 0; fl_gscid = 0; fl_pscid = 0; fl_vpn = 0;
        fl_ppn = 0; fl_perm = 0;
        iv_en = 0; iv_use_gscid = 0; iv_use_pscid = 0; iv_use_vpn = 0; iv_tag = 0;
        iv_gscid = 0; iv_pscid = 0; iv_vpn = 0;
    endtask

    task automatic do_reset();
        idle();
        rst = 1;
        for (int i = 0; i < N; i++) begin
            m_tag[i] = 0; m_g[i] = 0; m_p[i] = 0; m_v[i] = 0; m_ppn[i] = 0; m_perm[i] = 0;
        end
        m_ptr = 0;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    task automatic drive_fill(input logic [3:0] fs, input logic [3:0] gs, input logic [15:0] g,
                              input logic [19:0] p, input logic [43:0] v, input logic [43:0] pp,
                              input logic [1:0] pm);
        fl_en = 1; fl_fs_mode = fs; fl_gs_mode = gs; fl_gscid = g; fl_pscid = p;
        fl_vpn = v; fl_ppn = pp; fl_perm = pm;
    endtask

    task automatic drive_inval(input logic [2:0] use3, input logic [1:0] t, input logic [15:0] g,
                               input logic [19:0] p, input logic [43:0] v);
        iv_en = 1; iv_use_gscid = use3[0]; iv_use_pscid = use3[1]; iv_use_vpn = use3[2];
        iv_tag = t; iv_gscid = g; iv_pscid = p; iv_vpn = v;
    endtask

    task automatic drive_look(input logic [1:0] t, input logic [15:0] g, input logic [19:0] p,
                              input logic [43:0] v);
        lk_req = 1; lk_fs_mode = fs_for(t); lk_gs_mode = gs_for(t);
        lk_gscid = g; lk_pscid = p; lk_vpn = v;
    endtask

    task automatic fill(input logic [3:0] fs, input logic [3:0] gs, input logic [15:0] g,
                        input logic [19:0] p, input logic [43:0] v, input logic [43:0] pp,
                        input logic [1:0] pm);
        drive_fill(fs, gs, g, p, v, pp, pm);
        model_fill(tag_of(fs, gs), g, p, v, pp, pm);
        @(negedge clk);
        idle();
    endtask

    task automatic inval(input logic [2:0] use3, input logic [1:0] t, input logic [15:0] g,
                         input logic [19:0] p, input logic [43:0] v);
        drive_inval(use3, t, g, p, v);
        model_inval(use3, t, g, p, v);
        @(negedge clk);
        idle();
    endtask

    task automatic sample(input string rq, input logic [63:0] exp);
        logic [63:0] act;
        act = {17'd0, lk_hit, lk_perm, lk_ppn};
        chk(act == exp && lk_rsp_valid, rq, act, exp);
    endtask

    task automatic look(input logic [1:0] t, input logic [15:0] g, input logic [19:0] p,
                        input logic [43:0] v, input string rq);
        logic [63:0] exp;
        exp = model_look(t, g, p, v);
        drive_look(t, g, p, v);
        @(negedge clk);
        idle();
        sample(rq, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] e;
        do_reset();
        // R1: reset state
        chk(lk_rsp_valid == 0, "R1 rsp_valid after reset", 64'(lk_rsp_valid), 64'd0);
        for (int t = 0; t < 4; t++) look(2'(t), 16'd0, 20'd0, 44'd0, "R1 empty cache misses");

        // R2 and R4: tag derivation sweep over all mode encodings
        for (int fs = 0; fs < 16; fs++) begin
            for (int gs = 0; gs < 16; gs++) begin
                logic [1:0] et;
                et = 2'((gs != 0 ? 2 : 0) + (fs != 0 ? 1 : 0));
                fill(4'(fs), 4'(gs), 16'd7, 20'd9, 44'(fs * 16 + gs), 44'(fs * 16 + gs + 100),
                     2'(1 + (fs % 3)));
                look(et, 16'd7, 20'd9, 44'(fs * 16 + gs), "R2 R4 fill tag hits");
                look(et ^ 2'd1, 16'd7, 20'd9, 44'(fs * 16 + gs), "R2 other tag misses");
            end
        end

        // R5: round robin and in-place refill
        do_reset();
        for (int i = 0; i < N; i++) fill(4'd9, 4'd0, 16'd3, 20'd4, 44'(i), 44'(i + 500), 2'd3);
        for (int i = 0; i < N; i++) look(2'd1, 16'd3, 20'd4, 44'(i), "R5 all slots hit");
        fill(4'd9, 4'd0, 16'd3, 20'd4, 44'(N), 44'd999, 2'd1);
        look(2'd1, 16'd3, 20'd4, 44'd0, "R5 slot0 evicted");
        look(2'd1, 16'd3, 20'd4, 44'(N), "R5 new key hits");
        fill(4'd9, 4'd0, 16'd3, 20'd4, 44'd5, 44'd777, 2'd2);
        look(2'd1, 16'd3, 20'd4, 44'd5, "R5 in-place refill");
        look(2'd1, 16'd3, 20'd4, 44'd1, "R5 pointer held on refill");
        fill(4'd9, 4'd0, 16'd3, 20'd4, 44'(N + 1), 44'd888, 2'd1);
        look(2'd1, 16'd3, 20'd4, 44'd1, "R5 slot1 evicted next");
        look(2'd1, 16'd3, 20'd4, 44'd2, "R5 slot2 kept");

        // R6 and R9: every enable combination
        for (int m = 0; m < 8; m++) begin
            do_reset();
            for (int k = 0; k < 16; k++)
                fill(fs_for(k[3] ? 2'd3 : 2'd1), gs_for(k[3] ? 2'd3 : 2'd1), 16'(1 + k[0]),
                     20'(3 + k[1]), 44'(5 + k[2]), 44'(k + 40), 2'(1 + k % 3));
            inval(3'(m), 2'd1, 16'd1, 20'd3, 44'd5);
            for (int k = 0; k < 16; k++)
                look(k[3] ? 2'd3 : 2'd1, 16'(1 + k[0]), 20'(3 + k[1]), 44'(5 + k[2]),
                     k[3] ? "R9 other tag untouched" : "R6 masked invalidation");
        end

        // R7: same-cycle invalidation and fill are not seen by a lookup
        do_reset();
        fill(4'd9, 4'd0, 16'd11, 20'd12, 44'd13, 44'd14, 2'd3);
        e = model_look(2'd1, 16'd11, 20'd12, 44'd13);
        drive_inval(3'd0, 2'd1, 16'd0, 20'd0, 44'd0);
        drive_look(2'd1, 16'd11, 20'd12, 44'd13);
        model_inval(3'd0, 2'd1, 16'd0, 20'd0, 44'd0);
        @(negedge clk);
        idle();
        sample("R7 lookup sees pre-invalidation", e);
        look(2'd1, 16'd11, 20'd12, 44'd13, "R7 next lookup misses");
        e = model_look(2'd2, 16'd21, 20'd22, 44'd23);
        drive_fill(4'd0, 4'd5, 16'd21, 20'd22, 44'd23, 44'd24, 2'd1);
        drive_look(2'd2, 16'd21, 20'd22, 44'd23);
        model_fill(2'd2, 16'd21, 20'd22, 44'd23, 44'd24, 2'd1);
        @(negedge clk);
        idle();
        sample("R7 lookup sees pre-fill", e);
        look(2'd2, 16'd21, 20'd22, 44'd23, "R7 fill visible next cycle");

        // R8: fill survives a same-cycle invalidation
        do_reset();
        fill(4'd9, 4'd0, 16'd31, 20'd32, 44'd33, 44'd34, 2'd3);
        drive_inval(3'd0, 2'd1, 16'd0, 20'd0, 44'd0);
        drive_fill(4'd9, 4'd0, 16'd41, 20'd42, 44'd43, 44'd44, 2'd2);
        model_inval(3'd0, 2'd1, 16'd0, 20'd0, 44'd0);
        model_fill(2'd1, 16'd41, 20'd42, 44'd43, 44'd44, 2'd2);
        @(negedge clk);
        idle();
        look(2'd1, 16'd31, 20'd32, 44'd33, "R8 old entry cleared");
        look(2'd1, 16'd41, 20'd42, 44'd43, "R8 filled entry kept");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule